// File: doc/BRIEF.md
# Demand-Paced Single-Channel DMA Mover

This block is one DMA channel. It copies a programmed number of bytes from a source address to a destination address. The copy runs as a series of transfers. Each transfer is one read burst from the source, followed by one or two writes that put every byte read at the destination. A peripheral paces the copy with an active-low request line. The channel tells the peripheral that its side is being accessed by pulling an active-low acknowledge low during that access. The acknowledge falls in the same cycle as the address strobe of that access.

Software programs the source, destination, byte count and control word through a small select/write port, and reads them back through the same select.

Each read is sized by three things:
- the programmed burst limit,
- the position of the source address within a limit-sized window,
- the bytes still to move.

A write that would cross a limit-sized window at the destination is split into two accesses. In demand mode, a new transfer starts only while the channel is idle or in the arbitration cycle. The arbitration cycle is the cycle in which the last write of the current transfer is granted. In block mode the request line is ignored. When the count reaches zero, the channel drops its enable bit and raises a one-cycle done pulse.

The memory side is a plain request/grant port. The block holds an access on `mem_req` until `mem_gnt` is high on a rising edge. Read data is taken on that edge. Byte 0 of a data bus is the byte at `mem_addr`.

Top module: `dma_demand_chan`

## Requirements
- R1: After reset, `mem_req` and `done` are low and `dack_n` is high. Every register reads back as zero.
- R2: Let L be the burst limit, s the source address and c the remaining count. A read is `min(L - (s mod L), c)` bytes. No access crosses an L-aligned window.
- R3: A transfer of n bytes to destination d is written first as `min(n, L - (d mod L))` bytes at d. Any remainder is written as a second access at the next L boundary. The bytes keep their source order, with byte 0 of a data bus at the access address.
- R4: The source address grows by each read length. The destination address grows by each write length and the count shrinks by it. An access keeps its address, length and direction until it is granted.
- R5: `dack_n` is low only while an access to the device side is pending. If the device-side bit is 0, reads are device-side; if it is 1, writes are. `ale` is high in the first cycle of every access, and `dack_n` only falls in a cycle where `ale` is high.
- R6: In demand mode, `dreq_n` is captured on every rising edge. A low value captured while the channel is enabled and idle puts `mem_req` high after the following edge. At the arbitration cycle, the next transfer starts only if the captured request is active. Otherwise the channel goes idle.
- R7: In block mode, `dreq_n` is ignored. Transfers follow each other until the count is zero. A request held low in demand mode moves the same bytes in the same access sequence.
- R8: When the count reaches zero, the enable bit is cleared and `done` is high for exactly one cycle, the cycle right after the edge that granted the final write.
- R9: Clearing the enable bit during a transfer lets that transfer's writes finish and starts no further transfer. `done` is not raised.
- R10: Writes to the source, destination or count register are ignored while an access is in progress. While idle, they take effect on the next edge.
- R11: A limit code k from 0 to 5 gives a limit of 2^k bytes. Codes 6 and 7 give 32 bytes.
- R12: `cfg_sel` picks the register: 0 source, 1 destination, 2 count, 3 control. The control word fields are:
  - bit 0: enable
  - bit 1: block mode
  - bit 2: device is the destination
  - bits 6:4: limit code
  - bit 8: busy (read-only)

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select for write and readback |
| cfg_wdata | input | ADDR_W | Register write value |
| cfg_rdata | output | ADDR_W | Readback of the selected register |
| dreq_n | input | 1 | Peripheral transfer request, active low |
| dack_n | output | 1 | Device-side access acknowledge, active low |
| ale | output | 1 | Address strobe, first cycle of each access |
| mem_req | output | 1 | Access pending |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Access byte address |
| mem_len | output | MAX_LOG+1 | Access length in bytes |
| mem_wdata | output | 8<<MAX_LOG | Write data, byte 0 at mem_addr |
| mem_gnt | input | 1 | Access completes on this edge |
| mem_rdata | input | 8<<MAX_LOG | Read data, valid with mem_gnt |
| done | output | 1 | One-cycle terminal-count pulse |

## Verification
A request driven low before rising edge k is captured at k. `mem_req` is high after edge k+1, so the bench checks for low at the falling edge after k and for high one falling edge later. `done` appears after the edge that grants the final write and is gone one cycle later, so the bench counts pulses at every falling edge. A register write is held across exactly one rising edge and read back at the next falling edge. Every access is logged at the falling edge where the bench grants it, while the address, length and acknowledge are still stable. That log is compared with a sequence computed from the sizing rules.

// File: rtl/dma_pkg.sv
package dma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR1  = 2'd2,
    ST_WR2  = 2'd3
  } dma_st_e;

  localparam logic [1:0] SEL_SRC = 2'd0;
  localparam logic [1:0] SEL_DST = 2'd1;
  localparam logic [1:0] SEL_CNT = 2'd2;
  localparam logic [1:0] SEL_CTL = 2'd3;

  localparam int CTL_EN     = 0;
  localparam int CTL_BLK    = 1;
  localparam int CTL_DEVDST = 2;
  localparam int CTL_CODE   = 4;
  localparam int CTL_BUSY   = 8;

endpackage

// File: rtl/dma_req_sampler.sv
module dma_req_sampler #(
  parameter int STAGES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_n,
  output logic req_seen
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d[0] = ~req_n;
    for (int i = 1; i < STAGES; i++) begin
      sh_d[i] = sh_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign req_seen = sh_q[STAGES-1];

endmodule

// File: rtl/dma_burst_calc.sv
module dma_burst_calc #(
  parameter int CNT_W   = 16,
  parameter int MAX_LOG = 5
) (
  input  logic [2:0]         code,
  input  logic [MAX_LOG-1:0] src_lo,
  input  logic [MAX_LOG-1:0] dst_lo,
  input  logic [CNT_W-1:0]   cnt,
  input  logic [MAX_LOG:0]   tot,
  output logic [MAX_LOG:0]   lim,
  output logic [MAX_LOG:0]   rd_len,
  output logic [MAX_LOG:0]   wr_len
);

  localparam int LEN_W = MAX_LOG + 1;

  logic [2:0]       code_eff;
  logic [LEN_W-1:0] mask;
  logic [LEN_W-1:0] src_room;
  logic [LEN_W-1:0] dst_room;

  always_comb begin
    code_eff = (code > 3'(MAX_LOG)) ? 3'(MAX_LOG) : code;
    lim      = LEN_W'(1) << code_eff;
    mask     = lim - LEN_W'(1);
    src_room = lim - ({1'b0, src_lo} & mask);
    dst_room = lim - ({1'b0, dst_lo} & mask);
    rd_len   = (cnt < CNT_W'(src_room)) ? cnt[LEN_W-1:0] : src_room;
    wr_len   = (tot < dst_room) ? tot : dst_room;
  end

endmodule

// File: rtl/dma_stage_buf.sv
module dma_stage_buf #(
  parameter int MAX_LOG = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cap,
  input  logic [(8<<MAX_LOG)-1:0] rdata,
  input  logic [MAX_LOG:0]        off,
  output logic [(8<<MAX_LOG)-1:0] wdata
);

  localparam int DATA_W = 8 << MAX_LOG;

  logic [DATA_W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else if (cap) begin
      stg_q <= rdata;
    end
  end

  assign wdata = stg_q >> {off, 3'b000};

endmodule

// File: rtl/dma_demand_chan.sv
module dma_demand_chan
  import dma_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16,
  parameter int MAX_LOG    = 5,
  parameter int REQ_STAGES = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [1:0]              cfg_sel,
  input  logic [ADDR_W-1:0]       cfg_wdata,
  output logic [ADDR_W-1:0]       cfg_rdata,
  input  logic                    dreq_n,
  output logic                    dack_n,
  output logic                    ale,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [MAX_LOG:0]        mem_len,
  output logic [(8<<MAX_LOG)-1:0] mem_wdata,
  input  logic                    mem_gnt,
  input  logic [(8<<MAX_LOG)-1:0] mem_rdata,
  output logic                    done
);

  localparam int LEN_W  = MAX_LOG + 1;
  localparam int DATA_W = 8 << MAX_LOG;

  dma_st_e          st_q, st_d;
  logic [ADDR_W-1:0] src_q, src_d;
  logic [ADDR_W-1:0] dst_q, dst_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              en_q, en_d;
  logic              blk_q, blk_d;
  logic              devdst_q, devdst_d;
  logic [2:0]        code_q, code_d;
  logic [LEN_W-1:0]  tot_q, tot_d;
  logic [LEN_W-1:0]  off_q, off_d;
  logic              started_q, started_d;
  logic              done_q, done_d;

  logic              busy;
  logic              req_seen;
  logic              cap;
  logic              xfer_end;
  logic [LEN_W-1:0]  lim_w;
  logic [LEN_W-1:0]  rd_len;
  logic [LEN_W-1:0]  wr_len;
  logic [ADDR_W-1:0] ctl_word;

  dma_req_sampler #(.STAGES(REQ_STAGES)) u_samp (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_n    (dreq_n),
    .req_seen (req_seen)
  );

  dma_burst_calc #(.CNT_W(CNT_W), .MAX_LOG(MAX_LOG)) u_calc (
    .code   (code_q),
    .src_lo (src_q[MAX_LOG-1:0]),
    .dst_lo (dst_q[MAX_LOG-1:0]),
    .cnt    (cnt_q),
    .tot    (tot_q),
    .lim    (lim_w),
    .rd_len (rd_len),
    .wr_len (wr_len)
  );

  dma_stage_buf #(.MAX_LOG(MAX_LOG)) u_buf (
    .clk   (clk),
    .rst_n (rst_n),
    .cap   (cap),
    .rdata (mem_rdata),
    .off   (off_q),
    .wdata (mem_wdata)
  );

  assign busy = (st_q != ST_IDLE);

  // next-state logic
  always_comb begin
    st_d      = st_q;
    src_d     = src_q;
    dst_d     = dst_q;
    cnt_d     = cnt_q;
    en_d      = en_q;
    blk_d     = blk_q;
    devdst_d  = devdst_q;
    code_d    = code_q;
    tot_d     = tot_q;
    off_d     = off_q;
    done_d    = 1'b0;
    cap       = 1'b0;
    xfer_end  = 1'b0;
    started_d = busy && !mem_gnt;

    if (cfg_we) begin
      unique case (cfg_sel)
        SEL_SRC: if (!busy) src_d = cfg_wdata;
        SEL_DST: if (!busy) dst_d = cfg_wdata;
        SEL_CNT: if (!busy) cnt_d = cfg_wdata[CNT_W-1:0];
        default: begin
          en_d     = cfg_wdata[CTL_EN];
          blk_d    = cfg_wdata[CTL_BLK];
          devdst_d = cfg_wdata[CTL_DEVDST];
          code_d   = cfg_wdata[CTL_CODE +: 3];
        end
      endcase
    end

    unique case (st_q)
      ST_IDLE: begin
        if (en_q && (blk_q || req_seen) && (cnt_q != '0)) begin
          st_d = ST_RD;
        end
      end
      ST_RD: begin
        if (mem_gnt) begin
          cap   = 1'b1;
          tot_d = rd_len;
          off_d = '0;
          src_d = src_q + ADDR_W'(rd_len);
          st_d  = ST_WR1;
        end
      end
      ST_WR1: begin
        if (mem_gnt) begin
          dst_d = dst_q + ADDR_W'(wr_len);
          cnt_d = cnt_q - CNT_W'(wr_len);
          if (wr_len != tot_q) begin
            tot_d = tot_q - wr_len;
            off_d = wr_len;
            st_d  = ST_WR2;
          end else begin
            xfer_end = 1'b1;
          end
        end
      end
      default: begin
        if (mem_gnt) begin
          dst_d    = dst_q + ADDR_W'(tot_q);
          cnt_d    = cnt_q - CNT_W'(tot_q);
          xfer_end = 1'b1;
        end
      end
    endcase

    // arbitration cycle: last write of the transfer is granted
    if (xfer_end) begin
      if (cnt_d == '0) begin
        en_d   = 1'b0;
        done_d = 1'b1;
        st_d   = ST_IDLE;
      end else if (en_d && (blk_d || req_seen)) begin
        st_d = ST_RD;
      end else begin
        st_d = ST_IDLE;
      end
    end
  end

  // state and address registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      src_q     <= '0;
      dst_q     <= '0;
      cnt_q     <= '0;
      started_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      st_q      <= st_d;
      src_q     <= src_d;
      dst_q     <= dst_d;
      cnt_q     <= cnt_d;
      started_q <= started_d;
      done_q    <= done_d;
    end
  end

  // control fields
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      blk_q    <= 1'b0;
      devdst_q <= 1'b0;
      code_q   <= '0;
    end else begin
      en_q     <= en_d;
      blk_q    <= blk_d;
      devdst_q <= devdst_d;
      code_q   <= code_d;
    end
  end

  // per-transfer length bookkeeping, loaded only on grants
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tot_q <= '0;
      off_q <= '0;
    end else if (busy && mem_gnt) begin
      tot_q <= tot_d;
      off_q <= off_d;
    end
  end

  always_comb begin
    mem_req = busy;
    mem_we  = (st_q == ST_WR1) || (st_q == ST_WR2);
    unique case (st_q)
      ST_RD:   begin mem_addr = src_q; mem_len = rd_len; end
      ST_WR1:  begin mem_addr = dst_q; mem_len = wr_len; end
      ST_WR2:  begin mem_addr = dst_q; mem_len = tot_q;  end
      default: begin mem_addr = src_q; mem_len = '0;     end
    endcase
  end

  assign ale    = busy && !started_q;
  assign dack_n = !(busy && (devdst_q ? mem_we : !mem_we));
  assign done   = done_q;

  always_comb begin
    ctl_word                 = '0;
    ctl_word[CTL_EN]         = en_q;
    ctl_word[CTL_BLK]        = blk_q;
    ctl_word[CTL_DEVDST]     = devdst_q;
    ctl_word[CTL_CODE +: 3]  = code_q;
    ctl_word[CTL_BUSY]       = busy;
    unique case (cfg_sel)
      SEL_SRC: cfg_rdata = src_q;
      SEL_DST: cfg_rdata = dst_q;
      SEL_CNT: cfg_rdata = ADDR_W'(cnt_q);
      default: cfg_rdata = ctl_word;
    endcase
  end

endmodule

// File: rtl/dma_demand_chan_chk.sv
module dma_demand_chan_chk #(
  parameter int MAX_LOG = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               mem_req,
  input logic               mem_gnt,
  input logic               mem_we,
  input logic [MAX_LOG-1:0] addr_lo,
  input logic [MAX_LOG:0]   mem_len,
  input logic [MAX_LOG:0]   lim,
  input logic               dack_n,
  input logic               ale,
  input logic               done
);

  localparam int LEN_W = MAX_LOG + 1;

  logic [LEN_W:0] end_off;

  always_comb begin
    end_off = {1'b0, ({1'b0, addr_lo} & (lim - LEN_W'(1)))} + {1'b0, mem_len};
  end

  p_len_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_len != '0) && (mem_len <= lim));

  p_no_cross_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (end_off <= {1'b0, lim}));

  p_hold_until_gnt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> mem_req && $stable(mem_len) && $stable(addr_lo) && $stable(mem_we));

  p_ack_in_access_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !dack_n |-> mem_req);

  p_ack_fall_ale_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dack_n) |-> ale);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req);

endmodule

bind dma_demand_chan dma_demand_chan_chk #(.MAX_LOG(MAX_LOG)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .mem_req (mem_req),
  .mem_gnt (mem_gnt),
  .mem_we  (mem_we),
  .addr_lo (mem_addr[MAX_LOG-1:0]),
  .mem_len (mem_len),
  .lim     (lim_w),
  .dack_n  (dack_n),
  .ale     (ale),
  .done    (done)
);

// File: tb/tb_dma_demand_chan.sv
module tb_dma_demand_chan;

  localparam int ADDR_W = 32;
  localparam int MAXB   = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_we = 1'b0;
  logic [1:0]        cfg_sel = 2'd0;
  logic [31:0]       cfg_wdata = '0;
  logic [31:0]       cfg_rdata;
  logic              dreq_n = 1'b1;
  logic              dack_n, ale, mem_req, mem_we, done;
  logic [31:0]       mem_addr;
  logic [5:0]        mem_len;
  logic [MAXB*8-1:0] mem_wdata;
  logic              mem_gnt = 1'b0;
  logic [MAXB*8-1:0] mem_rdata = '0;

  dma_demand_chan dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dreq_n(dreq_n),
    .dack_n(dack_n), .ale(ale), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_len(mem_len), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .done(done)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;

  logic [7:0]  mem [0:4095];
  int          n_log = 0;
  logic        lg_we   [0:63];
  logic [31:0] lg_addr [0:63];
  int          lg_len  [0:63];
  logic        lg_dack [0:63];
  logic        cur_dack = 1'b1;
  int          lat = 0;
  int          wcnt = 0;
  int          n_done = 0;
  int          ack_err = 0;

  int          ex_n;
  logic        ex_we   [0:63];
  logic [31:0] ex_addr [0:63];
  int          ex_len  [0:63];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  // memory model: decides grants and logs accesses on falling edges
  always @(negedge clk) begin
    cyc++;
    if (done) n_done++;
    if (!dack_n && !mem_req) ack_err++;
    if (mem_req) begin
      if (ale) cur_dack = dack_n;
      if (wcnt >= lat) begin
        mem_gnt = 1'b1;
        wcnt = 0;
        if (n_log < 64) begin
          lg_we[n_log] = mem_we; lg_addr[n_log] = mem_addr;
          lg_len[n_log] = int'(mem_len); lg_dack[n_log] = cur_dack;
        end
        n_log++;
        if (mem_we) begin
          for (int i = 0; i < int'(mem_len); i++)
            mem[(mem_addr + i) & 32'hfff] = mem_wdata[i*8 +: 8];
        end else begin
          for (int i = 0; i < MAXB; i++)
            mem_rdata[i*8 +: 8] = mem[(mem_addr + i) & 32'hfff];
        end
      end else begin
        mem_gnt = 1'b0;
        wcnt++;
      end
    end else begin
      mem_gnt = 1'b0;
      wcnt = 0;
    end
  end

  task automatic cfg_wr(input logic [1:0] sel, input logic [31:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_rd(input logic [1:0] sel, output logic [31:0] val);
    @(negedge clk);
    cfg_sel = sel;
    #0.5;
    val = cfg_rdata;
  endtask

  task automatic prep();
    for (int i = 0; i < 4096; i++) mem[i] = pat(i);
    n_log = 0; n_done = 0; ack_err = 0;
  endtask

  // expected access sequence built from the sizing rules (R2, R3, R11)
  task automatic build_seq(input int s, input int d, input int c, input int code);
    int lim, rem, rl, w1;
    lim = (code > 5) ? 32 : (1 << code);
    rem = c; ex_n = 0;
    while (rem > 0 && ex_n < 61) begin
      rl = lim - (s % lim); if (rem < rl) rl = rem;
      ex_we[ex_n] = 1'b0; ex_addr[ex_n] = s; ex_len[ex_n] = rl; ex_n++;
      w1 = lim - (d % lim); if (rl < w1) w1 = rl;
      ex_we[ex_n] = 1'b1; ex_addr[ex_n] = d; ex_len[ex_n] = w1; ex_n++;
      if (w1 < rl) begin
        ex_we[ex_n] = 1'b1; ex_addr[ex_n] = d + w1; ex_len[ex_n] = rl - w1; ex_n++;
      end
      s += rl; d += rl; rem -= rl;
    end
  endtask

  task automatic cmp_seq(input bit devdst, input string req);
    int bad = 0;
    logic expd;
    chk(n_log == ex_n, {req, " access count"}, n_log, ex_n);
    for (int i = 0; i < ex_n && i < n_log; i++) begin
      expd = !(devdst ? ex_we[i] : !ex_we[i]);
      if (lg_we[i] !== ex_we[i] || lg_addr[i] !== ex_addr[i] ||
          lg_len[i] != ex_len[i] || lg_dack[i] !== expd) bad++;
    end
    chk(bad == 0, {req, " access sequence"}, bad, 0);
  endtask

  task automatic cmp_data(input int s, input int d, input int c, input string req);
    int bad = 0;
    for (int i = 0; i < c; i++) if (mem[d + i] !== pat(s + i)) bad++;
    chk(bad == 0, {req, " destination bytes"}, bad, 0);
  endtask

  task automatic wait_done(input int limit);
    for (int i = 0; i < limit && n_done == 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // full block-mode run with end-state checks
  task automatic t_run(input int s, input int d, input int c, input int code,
                       input bit devdst, input int l, input string req);
    logic [31:0] v;
    prep(); lat = l;
    cfg_wr(2'd0, s); cfg_wr(2'd1, d); cfg_wr(2'd2, c);
    cfg_wr(2'd3, (code << 4) | (32'(devdst) << 2) | 32'h3);
    wait_done(3000);
    build_seq(s, d, c, code);
    cmp_seq(devdst, req);
    cmp_data(s, d, c, req);
    chk(n_done == 1, "R8 done pulse count", n_done, 1);
    chk(ack_err == 0, "R5 dack outside access", ack_err, 0);
    cfg_rd(2'd3, v); chk(v[0] == 1'b0 && v[8] == 1'b0, "R8 enable cleared", v, 0);
    cfg_rd(2'd2, v); chk(v == 0, "R8 count at zero", v, 0);
    cfg_rd(2'd0, v); chk(v == s + c, "R4 source advance", v, s + c);
    cfg_rd(2'd1, v); chk(v == d + c, "R4 destination advance", v, d + c);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk(mem_req == 1'b0, "R1 mem_req idle", mem_req, 0);
    chk(dack_n == 1'b1, "R1 dack_n high", dack_n, 1);
    chk(done == 1'b0, "R1 done low", done, 0);
    for (int i = 0; i < 4; i++) begin
      cfg_rd(2'(i), v);
      chk(v == 0, "R1 register zero", v, 0);
    end
  endtask

  task automatic t_demand();
    logic [31:0] v;
    prep(); lat = 0;
    cfg_wr(2'd0, 32'h600); cfg_wr(2'd1, 32'h700); cfg_wr(2'd2, 32);
    cfg_wr(2'd3, 32'h31);              // enable, demand, limit 8
    repeat (10) @(negedge clk);
    chk(n_log == 0, "R6 no start without request", n_log, 0);
    dreq_n = 1'b0;                     // captured at next rising edge
    @(negedge clk);
    chk(mem_req == 1'b0, "R6 not yet requesting", mem_req, 0);
    dreq_n = 1'b1;
    #0.5;
    chk(mem_req == 1'b0, "R6 still idle", mem_req, 0);
    @(negedge clk);
    chk(mem_req == 1'b1, "R6 start after capture", mem_req, 1);
    repeat (12) @(negedge clk);
    chk(n_log == 2, "R6 single transfer on short request", n_log, 2);
    cfg_rd(2'd2, v); chk(v == 24, "R6 count after one transfer", v, 24);
    dreq_n = 1'b0;
    wait_done(500);
    dreq_n = 1'b1;
    build_seq(32'h600, 32'h700, 32, 3);
    cmp_seq(1'b0, "R7 held request");
    cmp_data(32'h600, 32'h700, 32, "R7");
    chk(n_done == 1, "R8 done after demand run", n_done, 1);
  endtask

  task automatic t_disable();
    logic [31:0] v;
    prep(); lat = 3;
    cfg_wr(2'd0, 32'h800); cfg_wr(2'd1, 32'h900); cfg_wr(2'd2, 64);
    cfg_wr(2'd3, 32'h33);              // enable, block, limit 8
    for (int i = 0; i < 200 && n_log == 0; i++) @(negedge clk);
    cfg_wr(2'd2, 5);                   // lands while write pending
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'd3; cfg_wdata = 32'h32;   // enable off
    @(negedge clk);
    cfg_we = 1'b0;
    repeat (40) @(negedge clk);
    chk(n_log == 2, "R9 transfer finishes then stops", n_log, 2);
    chk(n_done == 0, "R9 no done pulse", n_done, 0);
    cfg_rd(2'd2, v); chk(v == 56, "R10 count write ignored while busy", v, 56);
    cfg_rd(2'd0, v); chk(v == 32'h808, "R9 source after one read", v, 32'h808);
    cfg_wr(2'd2, 5);
    cfg_rd(2'd2, v); chk(v == 5, "R10 count write while idle", v, 5);
    cfg_rd(2'd3, v); chk(v[0] == 1'b0 && v[1] == 1'b1, "R12 control readback", v, 32'h2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_run(32'h100, 32'h200, 64, 3, 1'b0, 0, "R7 aligned block");
    t_run(32'h103, 32'h305, 21, 3, 1'b0, 0, "R3 unaligned split");
    t_run(32'h400, 32'h480, 3, 4, 1'b0, 0, "R2 short count");
    t_run(32'hA01, 32'hB07, 13, 2, 1'b1, 1, "R5 device at destination");
    t_run(32'hC00, 32'hD00, 40, 7, 1'b0, 2, "R11 limit clamp");
    t_demand();
    t_disable();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule